// File: doc/BRIEF.md
# Programmable-Priority Interrupt Selector

This block chooses one interrupt to take from a 64-bit vector of pending, already-enabled sources that belong to one privilege level. Each source has an 8-bit priority register that software writes through a single-entry write port. A smaller number means a more urgent source. A written value of zero tells the block to use a fallback value. The fallback depends on where the source sits in a fixed built-in ranking, measured against the level's own external interrupt.

The selection is combinational from the pending vector and the registers. It produces a valid flag and the 6-bit number of the winner. When the advanced-ordering input is low, the registers are ignored and the lowest-numbered pending source wins. The pending vector is formed upstream, and routing across privilege levels also happens upstream.

Top module: `irq_prio_sel`

## Requirements
- R1: At reset, every priority register takes its source's rank from R10, and a source absent from the ranking takes 255. The exception is source EXT_SRC (default 11), whose register resets to 0.
- R2: With advanced ordering on, the pending source with the smallest effective priority wins.
- R3: With advanced ordering on, when several pending sources share the smallest effective priority, the one with the highest index wins.
- R4: A register value of 0 on source EXT_SRC gives it an effective priority equal to its own rank (25 for source 11).
- R5: A register value of 0 on any other source gives an effective priority of 1 when that source's rank is numerically smaller than the rank of EXT_SRC. Otherwise it gives 255.
- R6: Sources 0, 4, 8, 13, 14 and 15 are absent from the ranking. Each of them has a rank of 255.
- R7: With advanced ordering off, the lowest-numbered pending source wins, whatever the registers hold.
- R8: When no source is pending, irq_valid is 0 and irq_id is 0.
- R9: A priority write is stored on the rising clock edge where wr_en is high. The output follows it with no further delay and does not change before that edge.
- R10: The ranks run 1 to 58, from most to least urgent, in this order: 63,62,31,30,61,60, 59,58,29,28,57,56, 55,54,27,26,53,52, 51,50,25,24,49,48, then 11,3,7, 9,1,5, 12, 10,2,6, then 47,46,23,22,45,44, 43,42,21,20,41,40, 39,38,19,18,37,36, 35,34,17,16,33,32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv_en | input | 1 | 1 selects by programmed priority, 0 selects the lowest index |
| pend | input | 64 | Pending and enabled sources |
| wr_en | input | 1 | Priority register write strobe |
| wr_idx | input | 6 | Source whose register is written |
| wr_data | input | 8 | Priority value to store |
| irq_valid | output | 1 | Some source is pending |
| irq_id | output | 6 | Number of the winning source, 0 when none |

## Verification
The hardest case to reach is the zero-value fallback. It only shows when a source with a zeroed register competes against a source whose effective priority lies on the other side of the fallback value. The stimulus therefore writes specific sources to 0 and pairs each one with a partner chosen to straddle 1, 25 or 255. Equal-value ties are built on purpose in the same way, by writing two registers to the same number. Reset values show only through the order of winners, so the bench compares pairs of sources whose ranks are adjacent.

// File: rtl/irq_prio_sel.sv
module irq_prio_sel #(
  parameter int NSRC    = 64,
  parameter int PW      = 8,
  parameter int EXT_SRC = 11
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     adv_en,
  input  logic [NSRC-1:0]          pend,
  input  logic                     wr_en,
  input  logic [$clog2(NSRC)-1:0]  wr_idx,
  input  logic [PW-1:0]            wr_data,
  output logic                     irq_valid,
  output logic [$clog2(NSRC)-1:0]  irq_id
);
  localparam int IDW   = $clog2(NSRC);
  localparam int NPAD  = 1 << IDW;
  localparam int LV    = IDW;
  localparam int MAXP  = (1 << PW) - 1;
  localparam int NRANK = 58;

  function automatic int src_at(input int p);
    int g, k, q, s;
    int mid [10];
    mid = '{11, 3, 7, 9, 1, 5, 12, 10, 2, 6};
    s = -1;
    if (p < 24 || p >= 34) begin
      q = (p < 24) ? p : p - 34;
      g = q / 6;
      k = q % 6;
      case (k)
        0: s = 63 - 4*g;
        1: s = 62 - 4*g;
        2: s = 31 - 2*g;
        3: s = 30 - 2*g;
        4: s = 61 - 4*g;
        default: s = 60 - 4*g;
      endcase
      if (p >= 34) s = (k == 2 || k == 3) ? s - 8 : s - 16;
    end else begin
      s = mid[p-24];
    end
    return s;
  endfunction

  function automatic int rank_of(input int s);
    int r;
    r = MAXP;
    for (int p = 0; p < NRANK; p++)
      if (src_at(p) == s) r = p + 1;
    return r;
  endfunction

  localparam int EXT_DEF = rank_of(EXT_SRC);

  logic [PW-1:0] prio_q [NSRC];
  logic [PW-1:0] eff    [NSRC];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSRC; i++)
        prio_q[i] <= (i == EXT_SRC) ? '0 : PW'(rank_of(i));
    end else if (wr_en) begin
      prio_q[wr_idx] <= wr_data;
    end
  end

  always_comb begin
    for (int i = 0; i < NSRC; i++) begin
      if (prio_q[i] != '0)
        eff[i] = prio_q[i];
      else if (i == EXT_SRC)
        eff[i] = PW'(EXT_DEF);
      else if (rank_of(i) < EXT_DEF)
        eff[i] = PW'(1);
      else
        eff[i] = PW'(MAXP);
    end
  end

  logic          nv [LV+1][NPAD];
  logic [PW-1:0] np [LV+1][NPAD];
  logic [IDW-1:0] ni [LV+1][NPAD];

  always_comb begin
    for (int l = 0; l <= LV; l++)
      for (int n = 0; n < NPAD; n++) begin
        nv[l][n] = 1'b0;
        np[l][n] = '0;
        ni[l][n] = '0;
      end
    for (int n = 0; n < NPAD; n++) begin
      if (n < NSRC) begin
        nv[0][n] = pend[n];
        np[0][n] = eff[n];
      end
      ni[0][n] = IDW'(n);
    end
    for (int l = 1; l <= LV; l++)
      for (int n = 0; n < NPAD; n++)
        if (n < (NPAD >> l)) begin
          if (nv[l-1][2*n+1] &&
              (!nv[l-1][2*n] || (adv_en && np[l-1][2*n+1] <= np[l-1][2*n]))) begin
            nv[l][n] = 1'b1;
            np[l][n] = np[l-1][2*n+1];
            ni[l][n] = ni[l-1][2*n+1];
          end else begin
            nv[l][n] = nv[l-1][2*n];
            np[l][n] = np[l-1][2*n];
            ni[l][n] = ni[l-1][2*n];
          end
        end
  end

  assign irq_valid = nv[LV][0];
  assign irq_id    = nv[LV][0] ? ni[LV][0] : '0;

  localparam logic [NSRC-1:0] ONE = NSRC'(1);

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (pend == '0) |-> (!irq_valid && irq_id == '0)); // R8
  AST_WIN_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> pend[irq_id]); // R2
  AST_PLAIN_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en && irq_valid) |-> ((pend & ((ONE << irq_id) - ONE)) == '0)); // R7
  AST_PLAIN_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_en && $stable(adv_en) && $stable(pend)) |-> $stable(irq_id)); // R7
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (prio_q[$past(wr_idx)] == $past(wr_data))); // R9
endmodule

// File: tb/irq_prio_sel_bench.sv
module irq_prio_sel_bench;
  localparam int CLK_P = 10;
  localparam int NV = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        adv_en = 1'b1;
  logic [63:0] pend = '0;
  logic        wr_en = 1'b0;
  logic [5:0]  wr_idx = '0;
  logic [7:0]  wr_data = '0;
  logic        irq_valid;
  logic [5:0]  irq_id;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_prio_sel u_irq_prio_sel (
    .clk(clk), .rst_n(rst_n), .adv_en(adv_en), .pend(pend),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .irq_valid(irq_valid), .irq_id(irq_id)
  );

  function automatic logic [63:0] b(input int n);
    return 64'd1 << n;
  endfunction

  // {adv_en, pend, expected valid, expected id}, all at reset priorities
  localparam logic [71:0] VEC [NV] = '{
    {1'b1, 64'd0,                                   1'b0, 6'd0 },  // R8
    {1'b1, (64'd1<<63)|(64'd1<<0),                  1'b1, 6'd63},  // R2 R6
    {1'b1, (64'd1<<11)|(64'd1<<3),                  1'b1, 6'd11},  // R1 R4
    {1'b1, (64'd1<<11)|(64'd1<<62),                 1'b1, 6'd62},  // R10
    {1'b1, (64'd1<<0)|(64'd1<<4),                   1'b1, 6'd4 },  // R3 R6
    {1'b1, (64'd1<<13)|(64'd1<<32),                 1'b1, 6'd32},  // R6 R10
    {1'b0, (64'd1<<13)|(64'd1<<32),                 1'b1, 6'd13},  // R7
    {1'b0, (64'd1<<63)|(64'd1<<5),                  1'b1, 6'd5 },  // R7
    {1'b1, (64'd1<<1)|(64'd1<<5)|(64'd1<<9),        1'b1, 6'd9 },  // R10
    {1'b1, (64'd1<<10)|(64'd1<<2)|(64'd1<<6)|(64'd1<<12), 1'b1, 6'd12}, // R10
    {1'b1, (64'd1<<16)|(64'd1<<33),                 1'b1, 6'd16},  // R10
    {1'b0, 64'd0,                                   1'b0, 6'd0 },  // R8
    {1'b1, (64'd1<<47)|(64'd1<<24),                 1'b1, 6'd24},  // R10
    {1'b1, {64{1'b1}},                              1'b1, 6'd63},  // R2
    {1'b0, {64{1'b1}},                              1'b1, 6'd0 },  // R7
    {1'b1, (64'd1<<8)|(64'd1<<14)|(64'd1<<15),      1'b1, 6'd15}   // R3 R6
  };

  task automatic check(input logic ev, input logic [5:0] eid, input string tag);
    n_chk++;
    if (irq_valid !== ev || irq_id !== eid) begin
      n_bad++;
      $display("FAIL %s: got valid=%0b id=%0d, expected valid=%0b id=%0d",
               tag, irq_valid, irq_id, ev, eid);
    end
  endtask

  task automatic drive(input logic a, input logic [63:0] p);
    @(negedge clk);
    adv_en = a;
    pend = p;
    #1;
  endtask

  task automatic wr(input int idx, input int val);
    @(negedge clk);
    wr_en = 1'b1;
    wr_idx = 6'(idx);
    wr_data = 8'(val);
    @(negedge clk);
    wr_en = 1'b0;
    #1;
  endtask

  initial begin
    #(CLK_P * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #2;
    check(1'b0, 6'd0, "R8 in reset");
    pend = b(11) | b(3);
    #1;
    check(1'b1, 6'd11, "R1 in reset");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive(VEC[v][71], VEC[v][70:7]);
      check(VEC[v][6], VEC[v][5:0], $sformatf("table vector %0d", v));
    end

    // R9: write prio[0]=1, output unchanged before the edge, new after
    drive(1'b1, b(0) | b(62));
    wr_en = 1'b1; wr_idx = 6'd0; wr_data = 8'd1;
    #1;
    check(1'b1, 6'd62, "R9 before edge");
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    check(1'b1, 6'd0, "R9 after edge");

    wr(62, 1);
    check(1'b1, 6'd62, "R3 equal written values");
    wr(62, 7);
    check(1'b1, 6'd0, "R2 smaller value wins");
    wr(62, 0);
    check(1'b1, 6'd62, "R5 zero above ext gives 1");

    drive(1'b1, b(3) | b(13));
    check(1'b1, 6'd3, "R1 rank 26 beats 255");
    wr(3, 0);
    check(1'b1, 6'd13, "R5 zero below ext gives 255");
    drive(1'b0, b(3) | b(13));
    check(1'b1, 6'd3, "R7 registers ignored");

    drive(1'b1, b(11) | b(7));
    wr(11, 30);
    check(1'b1, 6'd7, "R2 ext written 30");
    wr(11, 0);
    check(1'b1, 6'd11, "R4 ext zero uses 25");
    drive(1'b1, b(11) | b(12));
    wr(12, 25);
    check(1'b1, 6'd12, "R4 ext default equals 25");

    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    drive(1'b1, b(3) | b(13));
    check(1'b1, 6'd3, "R1 reset restores rank");
    drive(1'b1, b(0) | b(62));
    check(1'b1, 6'd62, "R1 reset restores source 0");
    drive(1'b1, b(11) | b(12));
    check(1'b1, 6'd11, "R1 ext resets to zero");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule